// File: doc/BRIEF.md
# Sliced Blanking-Interval Record FIFO

This block buffers sliced vertical-blanking data on its way from a slicer to a host. The slicer hands over records: each record is a short header followed by its payload bytes, announced by a start strobe that carries the record's total byte count. The block admits a record only as a whole. If the free space cannot hold the entire declared length, nothing of the record is stored and a sticky overflow flag is raised. A later, shorter record that does fit is still taken.

The host drains the buffer one byte per read strobe through a registered data port. It watches a small status byte holding a sticky overflow flag, a sticky teletext-ready flag and a live empty flag. It can also see the occupancy in 16-bit words and receive an interrupt when that occupancy passes a programmable threshold. The sticky flags are cleared by writing ones to them. A one-cycle flush strobe discards everything stored. A host-access enable gates both directions: when it is low, reads return zero and new records are not taken.

Top module: `vbi_rec_fifo`

## Requirements
- R1: Storage holds DEPTH (512) bytes. A record with rec_len > 0 is admitted when rec_len is at most the free space at its start cycle. Its bytes, one per cycle with rec_valid, are read back in arrival order.
- R2: A record longer than the free space stores none of its bytes and sets status bit 7 on the following cycle. A later record that fits is still stored while bit 7 stays set.
- R3: Status bits 7 (overflow) and 5 (teletext ready) are sticky. They are cleared only by st_clr_we with a 1 in the matching bit of st_clr_mask. Reads do not clear them. A set in the same cycle as a clear wins.
- R4: Status bit 6 is 1 exactly when the FIFO holds no bytes, and writing to it has no effect. Status bits 4..0 read 0.
- R5: word_cnt equals the stored byte count divided by two, rounded down.
- R6: irq is 1 exactly when irq_en is 1 and word_cnt is strictly greater than the threshold. The threshold resets to 128 and is loaded by thr_we with thr_data.
- R7: A fifo_rst_we pulse empties the FIFO. It discards the stored bytes and abandons a record in progress, so that record's remaining bytes are not stored.
- R8: With host_en at 0, a read returns 00h and removes nothing. A record started while host_en is 0 is not stored and does not set bit 7.
- R9: A record started with both rec_bad and rec_drop at 1 is discarded without setting bit 7. rec_bad alone does not prevent storage.
- R10: A read while the FIFO is empty returns 00h and leaves the contents and count unchanged.
- R11: Status bit 5 is set on the cycle after the last byte of an admitted record started with rec_ttx at 1.
- R12: A rec_start during a record in progress is ignored. Bytes after the declared length are not stored. A read and a write in the same cycle keep the count and order correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_start | input | 1 | Record start strobe |
| rec_len | input | LEN_W | Total record bytes (header plus payload) |
| rec_ttx | input | 1 | Record carries teletext |
| rec_bad | input | 1 | Record was flagged with an error |
| rec_drop | input | 1 | Drop the record if it is flagged bad |
| rec_valid | input | 1 | Record byte valid |
| rec_byte | input | 8 | Record byte |
| host_en | input | 1 | Host-access enable |
| rd_stb | input | 1 | Host read strobe |
| rd_data | output | 8 | Read data, registered |
| status | output | 8 | Status: bit 7 overflow, bit 6 empty, bit 5 teletext ready |
| word_cnt | output | AW | Occupancy in 2-byte words |
| thr_we | input | 1 | Threshold load strobe |
| thr_data | input | AW | Threshold value |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Threshold interrupt |
| st_clr_we | input | 1 | Status clear strobe |
| st_clr_mask | input | 8 | Write-1-to-clear mask |
| fifo_rst_we | input | 1 | Flush strobe |

## Verification
Two pairs of functions can land in the same cycle. A host read can coincide with a record byte being written. A status clear can coincide with a rejection that sets the overflow bit. The first is provoked by random reads interleaved with record streaming: each read is judged against a queue model that pops before it pushes, so a read of an empty FIFO returns 00h even when a byte enters in that cycle. The second is driven directly, with a clear of bit 7 issued on the very cycle an oversize record starts, and the bit is expected to stay set.

// File: rtl/vbi_fifo_pkg.sv
package vbi_fifo_pkg;
  typedef enum logic [0:0] {ADM_IDLE, ADM_FILL} adm_state_e;
  localparam int unsigned ST_OVF   = 7;
  localparam int unsigned ST_EMPTY = 6;
  localparam int unsigned ST_TTX   = 5;
endpackage

// File: rtl/vbi_fifo_mem.sv
module vbi_fifo_mem #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vbi_fifo_admit.sv
module vbi_fifo_admit
  import vbi_fifo_pkg::*;
#(
  parameter int unsigned LEN_W = 10,
  parameter int unsigned OCC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             host_en,
  input  logic             rec_start,
  input  logic [LEN_W-1:0] rec_len,
  input  logic             rec_ttx,
  input  logic             rec_bad,
  input  logic             rec_drop,
  input  logic             rec_valid,
  input  logic [OCC_W-1:0] free_bytes,
  output logic             wr_en,
  output logic             reject,
  output logic             ttx_done
);
  adm_state_e       state_q, state_d;
  logic [LEN_W-1:0] remain_q, remain_d;
  logic             ttx_q, ttx_d;
  logic             eligible;

  assign eligible = rec_start && host_en && (rec_len != '0) && !(rec_bad && rec_drop);

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    ttx_d    = ttx_q;
    wr_en    = 1'b0;
    reject   = 1'b0;
    ttx_done = 1'b0;
    unique case (state_q)
      ADM_IDLE: begin
        if (eligible) begin
          if (32'(rec_len) > 32'(free_bytes)) begin
            reject = 1'b1;
          end else begin
            state_d  = ADM_FILL;
            remain_d = rec_len;
            ttx_d    = rec_ttx;
          end
        end
      end
      ADM_FILL: begin
        if (rec_valid) begin
          wr_en    = 1'b1;
          remain_d = remain_q - LEN_W'(1);
          if (remain_q == LEN_W'(1)) begin
            state_d  = ADM_IDLE;
            ttx_done = ttx_q;
          end
        end
      end
      default: state_d = ADM_IDLE;
    endcase
    if (flush) begin
      state_d  = ADM_IDLE;
      wr_en    = 1'b0;
      reject   = 1'b0;
      ttx_done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ADM_IDLE;
      remain_q <= '0;
      ttx_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      ttx_q    <= ttx_d;
    end
  end

  // R7
  flush_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (state_q == ADM_IDLE));

  // R12
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ADM_FILL) && rec_start && !flush && !(rec_valid && remain_q == LEN_W'(1))
      |=> (state_q == ADM_FILL) && (remain_q == ($past(remain_q) - LEN_W'($past(rec_valid)))));
endmodule

// File: rtl/vbi_fifo_status.sv
module vbi_fifo_status
  import vbi_fifo_pkg::*;
#(
  parameter int unsigned WCW     = 9,
  parameter int unsigned THR_RST = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reject,
  input  logic           ttx_done,
  input  logic           clr_we,
  input  logic           clr_ovf,
  input  logic           clr_ttx,
  input  logic           empty,
  input  logic [WCW-1:0] word_cnt,
  input  logic           thr_we,
  input  logic [WCW-1:0] thr_data,
  input  logic           irq_en,
  output logic [7:0]     status,
  output logic           irq
);
  logic           ovf_q, ovf_d;
  logic           ttx_q, ttx_d;
  logic [WCW-1:0] thr_q, thr_d;

  always_comb begin
    ovf_d = reject   | (ovf_q & ~(clr_we & clr_ovf));
    ttx_d = ttx_done | (ttx_q & ~(clr_we & clr_ttx));
    thr_d = thr_we ? thr_data : thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      ttx_q <= 1'b0;
      thr_q <= WCW'(THR_RST);
    end else begin
      ovf_q <= ovf_d;
      ttx_q <= ttx_d;
      thr_q <= thr_d;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_OVF]   = ovf_q;
    status[ST_EMPTY] = empty;
    status[ST_TTX]   = ttx_q;
  end

  assign irq = irq_en && (word_cnt > thr_q);

  // R2
  reject_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> status[ST_OVF]);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_OVF] && !clr_we |=> status[ST_OVF]);

  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: rtl/vbi_rec_fifo.sv
module vbi_rec_fifo #(
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned LEN_W   = 10,
  parameter int unsigned THR_RST = 128,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned OCC_W  = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_start,
  input  logic [LEN_W-1:0] rec_len,
  input  logic             rec_ttx,
  input  logic             rec_bad,
  input  logic             rec_drop,
  input  logic             rec_valid,
  input  logic [7:0]       rec_byte,
  input  logic             host_en,
  input  logic             rd_stb,
  output logic [7:0]       rd_data,
  output logic [7:0]       status,
  output logic [AW-1:0]    word_cnt,
  input  logic             thr_we,
  input  logic [AW-1:0]    thr_data,
  input  logic             irq_en,
  output logic             irq,
  input  logic             st_clr_we,
  input  logic [7:0]       st_clr_mask,
  input  logic             fifo_rst_we
);
  logic [OCC_W-1:0] occ_q, occ_d, free_bytes;
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [7:0]       rd_data_q, rd_data_d, mem_rdata;
  logic             wr_en, reject, ttx_done, empty, pop;
  logic             unused_mask;

  assign unused_mask = ^{st_clr_mask[6], st_clr_mask[4:0]};
  assign empty       = (occ_q == '0);
  assign free_bytes  = OCC_W'(DEPTH) - occ_q;
  assign pop         = rd_stb && host_en && !empty && !fifo_rst_we;

  vbi_fifo_admit #(.LEN_W(LEN_W), .OCC_W(OCC_W)) i_admit (
    .clk, .rst_n, .flush(fifo_rst_we), .host_en, .rec_start, .rec_len,
    .rec_ttx, .rec_bad, .rec_drop, .rec_valid, .free_bytes,
    .wr_en, .reject, .ttx_done
  );

  vbi_fifo_mem #(.DW(8), .DEPTH(DEPTH)) i_mem (
    .clk, .we(wr_en), .waddr(wr_ptr_q), .wdata(rec_byte),
    .raddr(rd_ptr_q), .rdata(mem_rdata)
  );

  always_comb begin
    wr_ptr_d  = wr_ptr_q;
    rd_ptr_d  = rd_ptr_q;
    occ_d     = occ_q;
    rd_data_d = rd_data_q;
    if (rd_stb) begin
      rd_data_d = pop ? mem_rdata : 8'h00;
    end
    if (fifo_rst_we) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      occ_d    = '0;
    end else begin
      if (wr_en) wr_ptr_d = wr_ptr_q + AW'(1);
      if (pop)   rd_ptr_d = rd_ptr_q + AW'(1);
      occ_d = occ_q + OCC_W'(wr_en) - OCC_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      occ_q     <= '0;
      rd_data_q <= '0;
    end else begin
      wr_ptr_q  <= wr_ptr_d;
      rd_ptr_q  <= rd_ptr_d;
      occ_q     <= occ_d;
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data  = rd_data_q;
  assign word_cnt = occ_q[AW:1];

  vbi_fifo_status #(.WCW(AW), .THR_RST(THR_RST)) i_status (
    .clk, .rst_n, .reject, .ttx_done, .clr_we(st_clr_we),
    .clr_ovf(st_clr_mask[7]), .clr_ttx(st_clr_mask[5]), .empty,
    .word_cnt, .thr_we, .thr_data, .irq_en, .status, .irq
  );

  // R1
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && empty && !fifo_rst_we |=> (rd_data == 8'h00) && $stable(rd_ptr_q));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst_we |=> status[6] && (word_cnt == '0));

  // R8
  host_off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !host_en |=> (rd_data == 8'h00));
endmodule

// File: tb/test_vbi_rec_fifo.sv
module test_vbi_rec_fifo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rec_start, rec_ttx, rec_bad, rec_drop, rec_valid;
  logic [9:0] rec_len;
  logic [7:0] rec_byte;
  logic       host_en, rd_stb, thr_we, irq_en, st_clr_we, fifo_rst_we, irq;
  logic [7:0] rd_data, status, st_clr_mask;
  logic [8:0] word_cnt, thr_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] q[$];
  bit         m_ovf, m_ttx;
  int         m_thr;

  always #5 clk = ~clk;

  vbi_rec_fifo i_vbi_rec_fifo (
    .clk, .rst_n, .rec_start, .rec_len, .rec_ttx, .rec_bad, .rec_drop,
    .rec_valid, .rec_byte, .host_en, .rd_stb, .rd_data, .status, .word_cnt,
    .thr_we, .thr_data, .irq_en, .irq, .st_clr_we, .st_clr_mask, .fifo_rst_we
  );

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_status();
    return (int'(m_ovf) << 7) | (int'(q.size() == 0) << 6) | (int'(m_ttx) << 5);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_state(string tag);
    chk({tag, " R5 word count"}, int'(word_cnt), q.size() / 2);
    chk({tag, " R4 status"}, int'(status), exp_status());
    chk({tag, " R6 irq"}, int'(irq), int'(irq_en && (q.size() / 2 > m_thr)));
  endtask

  task automatic send_record(int len, bit ttx, bit bad, bit drop, bit mix);
    bit acc, elig;
    logic [7:0] expd;
    elig = host_en && len != 0 && !(bad && drop);
    acc  = elig && (len <= 512 - q.size());
    rec_start = 1'b1; rec_len = 10'(len); rec_ttx = ttx; rec_bad = bad; rec_drop = drop;
    tick();
    rec_start = 1'b0;
    if (elig && !acc) m_ovf = 1'b1;
    for (int i = 0; i < len; i++) begin
      bit do_rd;
      rec_valid = 1'b1;
      rec_byte  = 8'($urandom);
      do_rd     = mix && ($urandom % 3 == 0);
      rd_stb    = do_rd;
      expd      = 8'h00;
      if (do_rd && q.size() > 0) expd = q.pop_front();
      if (acc) q.push_back(rec_byte);
      tick();
      rec_valid = 1'b0;
      rd_stb    = 1'b0;
      if (do_rd) chk("R12 read beside write", int'(rd_data), int'(expd));
    end
    if (acc && ttx) m_ttx = 1'b1;
  endtask

  task automatic read_byte(string tag);
    logic [7:0] expd;
    expd = 8'h00;
    if (host_en && q.size() > 0) expd = q.pop_front();
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
    chk(tag, int'(rd_data), int'(expd));
  endtask

  task automatic clr_status(logic [7:0] mask);
    st_clr_we = 1'b1; st_clr_mask = mask;
    tick();
    st_clr_we = 1'b0; st_clr_mask = 8'h00;
    if (mask[7]) m_ovf = 1'b0;
    if (mask[5]) m_ttx = 1'b0;
  endtask

  task automatic flush();
    fifo_rst_we = 1'b1;
    tick();
    fifo_rst_we = 1'b0;
    q.delete();
  endtask

  task automatic set_thr(int v);
    thr_we = 1'b1; thr_data = 9'(v);
    tick();
    thr_we = 1'b0;
    m_thr = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd5151));
    rst_n = 1'b0;
    rec_start = 0; rec_len = 0; rec_ttx = 0; rec_bad = 0; rec_drop = 0;
    rec_valid = 0; rec_byte = 0; host_en = 1; rd_stb = 0; thr_we = 0;
    thr_data = 0; irq_en = 0; st_clr_we = 0; st_clr_mask = 0; fifo_rst_we = 0;
    m_ovf = 0; m_ttx = 0; m_thr = 128;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state (R4, R5, R6)
    check_state("reset");
    chk("reset rd_data", int'(rd_data), 0);

    // R10 empty read
    read_byte("R10 empty read");
    check_state("R10 after empty read");

    // R1, R11 small teletext record
    send_record(5, 1, 0, 0, 0);
    check_state("R11 ttx record");
    for (int i = 0; i < 5; i++) read_byte("R1 order");
    check_state("R1 drained");
    clr_status(8'h40);
    check_state("R4 empty not clearable");
    clr_status(8'h20);
    check_state("R3 clear ttx");

    // R2 rejection then fitting record
    send_record(500, 0, 0, 0, 0);
    send_record(20, 0, 0, 0, 0);
    check_state("R2 rejected");
    send_record(12, 0, 0, 0, 0);
    check_state("R2 fits after reject");
    chk("R1 full word count", int'(word_cnt), 256);

    // R6 interrupt threshold
    irq_en = 1'b1;
    tick();
    check_state("R6 irq above default");
    set_thr(256);
    check_state("R6 irq equal threshold");
    set_thr(255);
    check_state("R6 irq above threshold");
    irq_en = 1'b0;
    tick();
    check_state("R6 irq disabled");

    // R3 set beats clear in the same cycle
    rec_start = 1'b1; rec_len = 10'd30; st_clr_we = 1'b1; st_clr_mask = 8'h80;
    tick();
    rec_start = 1'b0; st_clr_we = 1'b0; st_clr_mask = 8'h00;
    m_ovf = 1'b1;
    chk("R3 set wins over clear", int'(status[7]), 1);

    // R3 reads do not clear
    read_byte("R3 read data");
    check_state("R3 overflow survives read");

    // R7 flush
    flush();
    check_state("R7 after flush");
    read_byte("R7 read after flush");
    clr_status(8'h80);
    check_state("R3 clear overflow");

    // R7 flush mid-record
    rec_start = 1'b1; rec_len = 10'd10;
    tick();
    rec_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      rec_valid = 1'b1; rec_byte = 8'($urandom);
      tick();
    end
    fifo_rst_we = 1'b1;
    tick();
    fifo_rst_we = 1'b0;
    q.delete();
    for (int i = 0; i < 6; i++) begin
      rec_byte = 8'($urandom);
      tick();
    end
    rec_valid = 1'b0;
    check_state("R7 abort record");

    // R8 host access disabled
    send_record(4, 0, 0, 0, 0);
    host_en = 1'b0;
    read_byte("R8 read disabled");
    check_state("R8 no pop");
    send_record(6, 0, 0, 0, 0);
    check_state("R8 record not stored");
    host_en = 1'b1;
    for (int i = 0; i < 4; i++) read_byte("R8 data intact");

    // R9 drop on error
    send_record(8, 0, 1, 1, 0);
    check_state("R9 dropped");
    send_record(2, 0, 1, 0, 0);
    check_state("R9 bad kept");
    read_byte("R9 kept byte 0");
    read_byte("R9 kept byte 1");

    // R12 start during record, excess bytes
    rec_start = 1'b1; rec_len = 10'd4;
    tick();
    rec_start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      rec_valid = 1'b1; rec_byte = 8'($urandom);
      rec_start = (i == 1); rec_len = (i == 1) ? 10'd2 : 10'd4;
      if (i < 4) q.push_back(rec_byte);
      tick();
    end
    rec_valid = 1'b0; rec_start = 1'b0;
    check_state("R12 busy start ignored");
    for (int i = 0; i < 4; i++) read_byte("R12 record bytes");

    // random phase
    for (int it = 0; it < 250; it++) begin
      int r;
      r = int'($urandom % 5);
      if (r < 2) begin
        send_record(1 + int'($urandom % 80), 1'($urandom), ($urandom % 4) == 0, 1'($urandom), 1);
        check_state("R1 random record");
      end else if (r < 4) begin
        int n;
        n = 1 + int'($urandom % 40);
        for (int k = 0; k < n; k++) read_byte("R1 random read");
      end else begin
        clr_status(8'($urandom) & 8'hE0);
        set_thr(int'($urandom % 260));
        irq_en = 1'($urandom);
        tick();
        check_state("R6 random status");
      end
    end
    while (q.size() > 0) read_byte("R1 drain");
    check_state("final");

    report();
    $finish;
  end
endmodule